// File: doc/BRIEF.md
# Multi-Format Serial PCM Stereo Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock that toggles between the two channels, and one data line) and turns each frame into a pair of parallel samples. A 3-bit format code, normally driven from a control register, selects one of eight framing variants at run time. The variants cover tail-aligned data, where the sample ends right at the frame-clock edge, head-aligned data, where it starts right at the edge, and the delayed-by-one framing used by I2S. Each variant uses 16, 20, 24 or 32 bits.

Everything runs on the bit clock. Whatever the configured width, every sample is delivered as a 32-bit two's-complement word with the sample in the upper bits. When the right-channel half of a frame has been fully received, the left and right words appear together with a one-cycle valid strobe. A serial audio source cannot be stalled, so the output has no ready input and no back-pressure. The consumer must take each pair in the cycle its strobe is high, and the pair stays on the outputs until the next strobe.

The per-half bit counter restarts on every frame-clock transition. Frames longer than the minimum are therefore accepted.

Top module: `pcm_serial_rx`

## Requirements
- R1: `fmt_sel` encodes the framing as follows: 0 tail-aligned 16-bit, 1 tail-aligned 20-bit, 2 head-aligned 24-bit, 3 delayed 24-bit, 4 tail-aligned 24-bit, 5 tail-aligned 32-bit, 6 head-aligned 32-bit, 7 delayed 32-bit.
- R2: Samples are two's complement and arrive MSB first. An N-bit sample is output as bits 31 down to 32-N of the output word, and the remaining low bits are zero.
- R3: `sdata` and `frame_clk` are sampled on the rising edge of `clk_bit`.
- R4: In tail-aligned codes, the sample's LSB is the last bit sampled before a frame-clock transition, and the N-1 bits before it hold the rest of the sample. All earlier bits of that half are ignored.
- R5: In head-aligned codes, the MSB is the bit sampled in the same cycle as the frame-clock transition, and bits after the N-th are ignored.
- R6: In delayed codes, the bit sampled at the transition is ignored and the MSB follows one cycle later. When a half holds exactly N bit periods, the LSB is taken from the first bit period of the next half.
- R7: `frame_clk` high marks the left channel in tail-aligned and head-aligned codes. `frame_clk` low marks the left channel in delayed codes.
- R8: Each completed right-channel sample raises `out_valid` for exactly one cycle. At that point `out_left` carries the most recent left sample and `out_right` carries the new right sample.
- R9: The bit position counter restarts at every frame-clock transition. Halves longer than the minimum, for example 96 bit clocks per frame, decode correctly.
- R10: The format code is taken only at frame-clock transitions. A change of `fmt_sel` in the middle of a half has no effect on that half.
- R11: While `rst_n` is low, `out_valid` is low and both outputs are zero. No sample is produced from the partial half that comes before the first frame-clock transition after reset.
- R12: Frames at the minimum length decode correctly: 32 bit clocks for code 0, 48 bit clocks for codes 1 to 4, and 64 bit clocks for codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Framing code from the control register |
| frame_clk | input | 1 | Channel-select frame clock |
| sdata | input | 1 | Serial sample data |
| out_valid | output | 1 | One-cycle strobe for a new stereo pair |
| out_left | output | 32 | Left sample, left-aligned, zero-filled |
| out_right | output | 32 | Right sample, left-aligned, zero-filled |

## Verification
Two events can fall on the same clock edge: the restart of the bit counter at a frame-clock transition, and the completion of the previous half's sample. This happens in every tail-aligned code. It also happens in a delayed code when a half is exactly N bits long, because the LSB then arrives at the transition itself. Frames at the minimum length make these two events coincide on purpose. The bench then judges the emitted pair bit-exactly against values it computes from the drive pattern, and it also checks that exactly one strobe is produced per frame. During every half, `fmt_sel` is switched to a different code and switched back before the next transition, so a format that is taken at the wrong moment corrupts the compared words.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int WORD_W  = 32;
  localparam int WIDTH_W = $clog2(WORD_W) + 1;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'd0,
    FMT_RJ20  = 3'd1,
    FMT_LJ24  = 3'd2,
    FMT_DLY24 = 3'd3,
    FMT_RJ24  = 3'd4,
    FMT_RJ32  = 3'd5,
    FMT_LJ32  = 3'd6,
    FMT_DLY32 = 3'd7
  } fmt_code_e;

  // tail_aligned: sample ends at the frame edge; delayed: MSB one slot late
  typedef struct packed {
    logic               tail_aligned;
    logic               delayed;
    logic [WIDTH_W-1:0] width;
  } fmt_info_t;

  function automatic fmt_info_t decode_fmt(input logic [2:0] code);
    fmt_info_t r;
    r = '0;
    case (fmt_code_e'(code))
      FMT_RJ16:  begin r.tail_aligned = 1'b1; r.width = WIDTH_W'(16); end
      FMT_RJ20:  begin r.tail_aligned = 1'b1; r.width = WIDTH_W'(20); end
      FMT_LJ24:  begin r.width = WIDTH_W'(24); end
      FMT_DLY24: begin r.delayed = 1'b1; r.width = WIDTH_W'(24); end
      FMT_RJ24:  begin r.tail_aligned = 1'b1; r.width = WIDTH_W'(24); end
      FMT_RJ32:  begin r.tail_aligned = 1'b1; r.width = WIDTH_W'(32); end
      FMT_LJ32:  begin r.width = WIDTH_W'(32); end
      default:   begin r.delayed = 1'b1; r.width = WIDTH_W'(32); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcm_frame_tracker.sv
module pcm_frame_tracker #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk,
  output logic             frame_edge,
  output logic             lr_q,
  output logic             synced_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] idx_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic primed_q;

  assign frame_edge = primed_q && (frame_clk != lr_q);
  // saturating: a counter parked at max never matches a capture slot
  assign idx_next   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      lr_q     <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= CNT_MAX;
    end else begin
      primed_q <= 1'b1;
      lr_q     <= frame_clk;
      cnt_q    <= frame_edge ? '0 : idx_next;
      if (frame_edge) synced_q <= 1'b1;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (cnt_q == '0)); // R9

  AST_SYNC_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced_q) |-> $past(frame_edge)); // R11
endmodule

// File: rtl/pcm_shift_capture.sv
module pcm_shift_capture
  import pcm_rx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdata,
  input  logic [WIDTH_W-1:0] width,
  output logic [W-1:0]       word_prev,
  output logic [W-1:0]       word_now
);
  logic [W-1:0]       sreg_q;
  logic [W-1:0]       with_now;
  logic [WIDTH_W-1:0] shamt;

  assign with_now  = {sreg_q[W-2:0], sdata};
  assign shamt     = WIDTH_W'(W) - width;
  // last N bits sit at the bottom; move them to the top, zeros fill below
  assign word_prev = sreg_q << shamt;
  assign word_now  = with_now << shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= with_now;
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sreg_q[0] == $past(sdata))); // R3
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic              frame_clk,
  input  logic              sdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right
);
  logic              frame_edge, lr_q, synced_q;
  logic [CNT_W-1:0]  cnt_q, idx_next, target;
  logic [2:0]        fmt_q;
  fmt_info_t         info;
  logic [WORD_W-1:0] word_prev, word_now, cap_word, hold_left;
  logic              cap_tail, cap_head, cap_any, half_left, cap_left, cap_right;

  pcm_frame_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk_bit), .rst_n(rst_n), .frame_clk(frame_clk),
    .frame_edge(frame_edge), .lr_q(lr_q), .synced_q(synced_q),
    .cnt_q(cnt_q), .idx_next(idx_next)
  );

  // fmt_q and lr_q still describe the finishing half on an edge cycle
  assign info   = decode_fmt(fmt_q);
  assign target = info.delayed ? CNT_W'(info.width) : CNT_W'(info.width) - CNT_W'(1);

  pcm_shift_capture #(.W(WORD_W)) u_shift (
    .clk(clk_bit), .rst_n(rst_n), .sdata(sdata), .width(info.width),
    .word_prev(word_prev), .word_now(word_now)
  );

  assign cap_tail  = frame_edge && synced_q && info.tail_aligned;
  assign cap_head  = !info.tail_aligned && (idx_next == target);
  assign cap_any   = cap_tail || cap_head;
  assign cap_word  = cap_tail ? word_prev : word_now;
  assign half_left = info.delayed ? !lr_q : lr_q;
  assign cap_left  = cap_any && half_left;
  assign cap_right = cap_any && !half_left;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q     <= FMT_LJ24;
      hold_left <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      if (frame_edge) fmt_q <= fmt_sel;
      out_valid <= cap_right;
      if (cap_left) hold_left <= cap_word;
      if (cap_right) begin
        out_left  <= hold_left;
        out_right <= cap_word;
      end
    end
  end

  AST_FMT_HOLD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !frame_edge |=> $stable(fmt_q)); // R10

  AST_VALID_PULSE: assert property (@(posedge clk_bit) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8

  AST_NO_EARLY_PAIR: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !synced_q |=> !out_valid); // R11

  AST_PAIR_HOLD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !cap_right |=> ($stable(out_left) && $stable(out_right))); // R8
endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int PAIRS      = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd2;
  logic        frame_clk = 1'b0;
  logic        sdata = 1'b0;
  logic        out_valid;
  logic [31:0] out_left, out_right;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_l [PAIRS];
  logic [31:0] exp_r [PAIRS];
  int   seen = 0;
  bit   mon_on = 0;
  bit   prev_valid = 0;
  int   cur_fmt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   carry_ok = 0;
  bit   carry_bit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serial_rx i_pcm_serial_rx (
    .clk_bit(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_clk(frame_clk),
    .sdata(sdata), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  // format table from R1
  function automatic int f_width(input int f);
    case (f) 0: return 16; 1: return 20; 5, 6, 7: return 32; default: return 24; endcase
  endfunction
  function automatic bit f_tail(input int f);
    return (f == 0 || f == 1 || f == 4 || f == 5);
  endfunction
  function automatic bit f_dly(input int f);
    return (f == 3 || f == 7);
  endfunction
  function automatic int f_min(input int f);  // R12
    if (f == 0) return 32;
    if (f <= 4) return 48;
    return 64;
  endfunction
  function automatic string f_req(input int f);
    if (f_tail(f)) return "R4";
    if (f_dly(f))  return "R6";
    return "R5";
  endfunction
  function automatic logic [31:0] f_mask(input int f);  // R2
    return 32'hFFFF_FFFF << (32 - f_width(f));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s fmt=%0d actual=%h expected=%h", req, cur_fmt, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (out_valid) begin
        check(!prev_valid, "R8 single-cycle strobe", 32'(prev_valid), 32'd0);
        if (seen < PAIRS) begin
          // R2 R7 R9 R10 R12 plus the alignment rule of the format
          check(out_left == exp_l[seen], {f_req(cur_fmt), " R7 left"}, out_left, exp_l[seen]);
          check(out_right == exp_r[seen], {f_req(cur_fmt), " R7 right"}, out_right, exp_r[seen]);
        end else begin
          check(1'b0, "R11 extra pair", 32'(seen), 32'(PAIRS));
        end
        seen++;
      end
      prev_valid = out_valid;
    end else begin
      prev_valid = 0;
    end
  end

  function automatic bit junk();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // drives one half; all changes at falling edges (R3)
  task automatic drive_half(input int f, input bit is_left, input logic [31:0] s,
                            input int h, input bit have);
    int  n = f_width(f);
    bit  lvl = f_dly(f) ? !is_left : is_left;  // R7
    for (int j = 0; j < h; j++) begin
      bit b;
      @(negedge clk);
      b = junk();
      if (j == 0 && carry_ok) b = carry_bit;
      if (have) begin
        if (f_tail(f)) begin
          if (j >= h - n) b = s[32 - n + (h - 1 - j)];
        end else if (f_dly(f)) begin
          if (j >= 1 && j <= n) b = s[32 - j];
        end else begin
          if (j < n) b = s[31 - j];
        end
      end
      frame_clk = lvl;
      sdata     = b;
      fmt_sel   = (j >= 2 && j < h - 2) ? 3'(f ^ 5) : 3'(f);  // R10 mid-half change
    end
    carry_ok  = have && f_dly(f) && (h == n);
    carry_bit = s[32 - n];
  endtask

  task automatic run_group(input int f, input int ratio, input int g);
    int h = ratio / 2;
    logic [31:0] sl [PAIRS];
    logic [31:0] sr [PAIRS];
    cur_fmt = f;
    mon_on  = 0;
    @(negedge clk);
    rst_n = 0;
    frame_clk = f_dly(f) ? 1'b1 : 1'b0;  // rests at right-channel level
    fmt_sel = 3'(f);
    carry_ok = 0;
    repeat (2) @(negedge clk);
    check(!out_valid && out_left == 0 && out_right == 0, "R11 reset state",
          out_left | out_right, 32'd0);
    rst_n = 1;
    for (int k = 0; k < PAIRS; k++) begin
      if (k == 0) begin
        sl[k] = 32'h8000_0000;
        sr[k] = 32'h7FFF_FFFF;
      end else begin
        sl[k] = (32'h9E37_79B9 * 32'(g * 8 + k * 2 + 1)) ^ 32'h5A5A_C3C3;
        sr[k] = (32'h85EB_CA6B * 32'(g * 8 + k * 2 + 2)) ^ 32'h3C3C_0FF0;
      end
      exp_l[k] = sl[k] & f_mask(f);
      exp_r[k] = sr[k] & f_mask(f);
    end
    seen   = 0;
    mon_on = 1;
    // a partial half before the first transition must yield nothing (R11)
    repeat (5) begin
      @(negedge clk);
      sdata = junk();
    end
    for (int k = 0; k < PAIRS; k++) begin
      drive_half(f, 1'b1, sl[k], h, 1'b1);
      drive_half(f, 1'b0, sr[k], h, 1'b1);
    end
    drive_half(f, 1'b1, 32'h0, h, 1'b0);
    repeat (3) @(negedge clk);
    check(seen == PAIRS, "R8 pair count", 32'(seen), 32'(PAIRS));
    mon_on = 0;
  endtask

  initial begin
    int g = 0;
    repeat (3) @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      run_group(f, f_min(f), g); g++;   // R12 minimum frame length
      run_group(f, 64, g);       g++;
      run_group(f, 96, g);       g++;   // R9 longer frames
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule